// File: doc/BRIEF.md
# Hashed Address Signature Register

This block keeps an approximate record of a set of cache-line addresses in a register of fixed length, as a Bloom filter does. Each address is cut down to its line number. It is then mapped by several independent fold functions, and each function picks one bit inside its own slice of the register. The register can absorb any number of addresses. Its answers may report a false match but never miss an address that was recorded.

Three copies are meant to run side by side in a near-memory coherence scheme. One records the lines an accelerator has read, one the lines it has written, and one the lines the host cores have written. A conflict check compares the accelerator read record with the host write record bit by bit, so no list of addresses has to be stored. After a conflict has been resolved, every record is wiped and the accelerator runs its work again.

Each copy accepts one address to record per cycle and answers one membership question per cycle. It exposes its whole bit vector so that it can be compared with a partner copy of the same shape. A wipe strobe empties it.

Top module: `addr_sig`

## Requirements
- R1: After reset, `sig_out` is all zero, `qry_hit` is 0 and `overlap` is 0 for any query address and any all-zero peer vector.
- R2: The register is split into NUM_HASH slices of PART_BITS bits, with slice j at bits [j*PART_BITS +: PART_BITS]. For slice j, let L be the line number `addr[ADDR_W-1:LINE_OFS]`. The index inside the slice is the XOR, over every bit i of L that is 1, of the one-hot value at index position (i + j*(i/IDX_W)) mod IDX_W, where IDX_W = log2(PART_BITS).
- R3: When `ins_valid` is 1 and `clr` is 0 at a rising edge, the slice bits selected for `ins_addr` are 1 after that edge, and every other bit keeps its value.
- R4: `qry_hit` is combinational. It is 1 exactly when every slice bit selected for `qry_addr` is 1, so every recorded address that has not since been wiped reads back as a hit.
- R5: When `clr` is 1 at a rising edge, the whole register is zero after that edge, even if `ins_valid` is 1 in the same cycle.
- R6: `overlap` is combinational. It is 1 exactly when `sig_out & peer_sig` has at least one 1 in every slice.
- R7: When `ins_valid` and `clr` are both 0 at a rising edge, `sig_out` does not change.
- R8: Apart from a wipe or a reset, no bit of the register ever returns from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Wipe strobe; wins over a record request in the same cycle |
| ins_valid | input | 1 | Record the address on `ins_addr` |
| ins_addr | input | ADDR_W | Byte address to record |
| qry_addr | input | ADDR_W | Byte address to test for membership |
| qry_hit | output | 1 | Every selected bit for `qry_addr` is set |
| sig_out | output | NUM_HASH*PART_BITS | Current register contents |
| peer_sig | input | NUM_HASH*PART_BITS | Partner register for the overlap test |
| overlap | output | 1 | The two vectors share a 1 in every slice |

## Verification
The checker assumes that `ins_valid`, `clr` and both address inputs are settled before each rising edge and never unknown once reset is released. It also assumes that `peer_sig` comes from a register of the same shape. The stimulus keeps within these limits: all inputs change only on falling edges, and the peer vector is the output of a second copy of the block. The read record and the write record are then filled with partly shared and partly disjoint addresses, so that the overlap test is driven both ways.

// File: rtl/addr_sig_pkg.sv
package addr_sig_pkg;

   typedef enum logic [1:0] {
      SIG_HOLD = 2'd0,
      SIG_SET  = 2'd1,
      SIG_WIPE = 2'd2
   } sig_op_e;

   function automatic sig_op_e sig_decode(input logic wipe, input logic rec);
      if (wipe)
         return SIG_WIPE;
      else if (rec)
         return SIG_SET;
      return SIG_HOLD;
   endfunction

endpackage

// File: rtl/sig_hash.sv
module sig_hash #(
   parameter int LINE_W = 26,
   parameter int IDX_W  = 6,
   parameter int SEL    = 0
) (
   input  logic [LINE_W-1:0] line,
   output logic [IDX_W-1:0]  idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < LINE_W; i++) begin
         idx[(i + SEL * (i / IDX_W)) % IDX_W] ^= line[i];
      end
   end
endmodule

// File: rtl/sig_store.sv
module sig_store
   import addr_sig_pkg::*;
#(
   parameter int SIG_W = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sig_op_e          op,
   input  logic [SIG_W-1:0] set_mask,
   output logic [SIG_W-1:0] sig
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig <= '0;
      end else begin
         case (op)
            SIG_WIPE: sig <= '0;
            SIG_SET:  sig <= sig | set_mask;
            default:  sig <= sig;
         endcase
      end
   end
endmodule

// File: rtl/sig_overlap.sv
module sig_overlap #(
   parameter int NUM_HASH  = 4,
   parameter int PART_BITS = 64
) (
   input  logic [NUM_HASH*PART_BITS-1:0] a_sig,
   input  logic [NUM_HASH*PART_BITS-1:0] b_sig,
   output logic                          hit
);
   logic [NUM_HASH-1:0] part_any;

   for (genvar j = 0; j < NUM_HASH; j++) begin : g_part
      assign part_any[j] = |(a_sig[j*PART_BITS +: PART_BITS] & b_sig[j*PART_BITS +: PART_BITS]);
   end

   assign hit = &part_any;
endmodule

// File: rtl/addr_sig.sv
module addr_sig
   import addr_sig_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LINE_OFS  = 6,
   parameter int NUM_HASH  = 4,
   parameter int PART_BITS = 64,
   localparam int SIG_W    = NUM_HASH * PART_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ins_valid,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [ADDR_W-1:0] qry_addr,
   output logic              qry_hit,
   output logic [SIG_W-1:0]  sig_out,
   input  logic [SIG_W-1:0]  peer_sig,
   output logic              overlap
);
   localparam int LINE_W = ADDR_W - LINE_OFS;
   localparam int IDX_W  = (PART_BITS > 1) ? $clog2(PART_BITS) : 1;

   if (NUM_HASH < 1) begin : g_bad_hash
      $error("addr_sig: NUM_HASH must be at least 1");
   end
   if (PART_BITS < 2 || (PART_BITS & (PART_BITS - 1)) != 0) begin : g_bad_part
      $error("addr_sig: PART_BITS must be a power of two of at least 2");
   end
   if (LINE_OFS < 1 || LINE_OFS >= ADDR_W) begin : g_bad_ofs
      $error("addr_sig: LINE_OFS must lie inside the address");
   end

   logic [LINE_W-1:0] ins_line, qry_line;
   logic              unused_ofs_bits;

   assign ins_line        = ins_addr[ADDR_W-1:LINE_OFS];
   assign qry_line        = qry_addr[ADDR_W-1:LINE_OFS];
   assign unused_ofs_bits = ^{ins_addr[LINE_OFS-1:0], qry_addr[LINE_OFS-1:0]};

   logic [SIG_W-1:0]    set_mask;
   logic [NUM_HASH-1:0] qry_part;

   for (genvar j = 0; j < NUM_HASH; j++) begin : g_hash
      logic [IDX_W-1:0] ins_idx, qry_idx;

      sig_hash #(.LINE_W(LINE_W), .IDX_W(IDX_W), .SEL(j)) u_ins_hash (
         .line (ins_line),
         .idx  (ins_idx)
      );
      sig_hash #(.LINE_W(LINE_W), .IDX_W(IDX_W), .SEL(j)) u_qry_hash (
         .line (qry_line),
         .idx  (qry_idx)
      );

      assign set_mask[j*PART_BITS +: PART_BITS] = PART_BITS'(1) << ins_idx;
      assign qry_part[j] = sig_out[j*PART_BITS + int'(qry_idx)];
   end

   sig_op_e op;
   assign op = sig_decode(clr, ins_valid);

   sig_store #(.SIG_W(SIG_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .set_mask (set_mask),
      .sig      (sig_out)
   );

   assign qry_hit = &qry_part;

   sig_overlap #(.NUM_HASH(NUM_HASH), .PART_BITS(PART_BITS)) u_overlap (
      .a_sig (sig_out),
      .b_sig (peer_sig),
      .hit   (overlap)
   );
endmodule

// File: rtl/addr_sig_chk.sv
module addr_sig_chk #(
   parameter int ADDR_W = 32,
   parameter int SIG_W  = 256,
   parameter int NUM_HASH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              ins_valid,
   input logic [ADDR_W-1:0] ins_addr,
   input logic [ADDR_W-1:0] qry_addr,
   input logic              qry_hit,
   input logic [SIG_W-1:0]  sig_out,
   input logic [SIG_W-1:0]  peer_sig,
   input logic              overlap
);
   a_r5_wipe: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sig_out == '0));

   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ins_valid) |=> $stable(sig_out));

   a_r8_no_bit_lost: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (($past(sig_out) & ~sig_out) == '0));

   a_r3_bounded_growth: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !clr) |=> ($countones(sig_out) <= $countones($past(sig_out)) + NUM_HASH));

   a_r4_recorded_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !clr) |=> ((qry_addr != $past(ins_addr)) || qry_hit));

   a_r6_overlap_shared: assert property (@(posedge clk) disable iff (!rst_n)
      overlap |-> ((sig_out & peer_sig) != '0));

   a_r4_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_out == '0) |-> !qry_hit);
endmodule

bind addr_sig addr_sig_chk #(.ADDR_W(ADDR_W), .SIG_W(SIG_W), .NUM_HASH(NUM_HASH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .ins_valid (ins_valid),
   .ins_addr  (ins_addr),
   .qry_addr  (qry_addr),
   .qry_hit   (qry_hit),
   .sig_out   (sig_out),
   .peer_sig  (peer_sig),
   .overlap   (overlap)
);

// File: tb/sim_addr_sig.sv
`timescale 1ns/1ps
module sim_addr_sig;
   localparam int AW = 32, OFS = 6, K = 4, P = 64, IW = 6, SW = K * P;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          clr_a = 0, ins_v_a = 0, clr_b = 0, ins_v_b = 0;
   logic [AW-1:0] ins_a = 0, qry_a = 0, ins_b = 0, qry_b = 0;
   logic          hit_a, hit_b, ovl_a, ovl_b;
   logic [SW-1:0] sig_a, sig_b;

   // u0: accelerator read record, u1: host write record
   addr_sig u0 (.clk(clk), .rst_n(rst_n), .clr(clr_a), .ins_valid(ins_v_a), .ins_addr(ins_a),
                .qry_addr(qry_a), .qry_hit(hit_a), .sig_out(sig_a), .peer_sig(sig_b), .overlap(ovl_a));
   addr_sig u1 (.clk(clk), .rst_n(rst_n), .clr(clr_b), .ins_valid(ins_v_b), .ins_addr(ins_b),
                .qry_addr(qry_b), .qry_hit(hit_b), .sig_out(sig_b), .peer_sig(sig_a), .overlap(ovl_b));

   int vectors = 0, miscompares = 0;
   logic [AW-1:0] set_a[$], set_b[$];

   // R2 slice index, written from the requirement text
   function automatic int slot(logic [AW-1:0] a, int j);
      int r = 0;
      for (int i = 0; i < AW - OFS; i++)
         if (a[OFS + i]) r ^= (1 << ((i + j * (i / IW)) % IW));
      return r;
   endfunction

   function automatic logic [SW-1:0] model_vec(logic [AW-1:0] s[$]);
      logic [SW-1:0] v = '0;
      foreach (s[n])
         for (int j = 0; j < K; j++) v[j * P + slot(s[n], j)] = 1'b1;
      return v;
   endfunction

   function automatic logic model_hit(logic [AW-1:0] s[$], logic [AW-1:0] q);
      for (int j = 0; j < K; j++) begin
         logic found = 0;
         foreach (s[n]) if (slot(s[n], j) == slot(q, j)) found = 1;
         if (!found) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic logic model_ovl(logic [AW-1:0] s[$], logic [AW-1:0] t[$]);
      for (int j = 0; j < K; j++) begin
         logic found = 0;
         foreach (s[n]) foreach (t[m]) if (slot(s[n], j) == slot(t[m], j)) found = 1;
         if (!found) return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic check1(string req, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic checkv(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // One cycle: drive on the falling edge, compare, then let the edge update the model.
   task automatic cyc(logic ca, logic va, logic [AW-1:0] ia, logic [AW-1:0] qa,
                      logic cb, logic vb, logic [AW-1:0] ib, logic [AW-1:0] qb);
      @(negedge clk);
      clr_a = ca; ins_v_a = va; ins_a = ia; qry_a = qa;
      clr_b = cb; ins_v_b = vb; ins_b = ib; qry_b = qb;
      #1;
      checkv("R3 R5 R7 R8 read record", sig_a, model_vec(set_a));
      checkv("R3 R5 R7 R8 write record", sig_b, model_vec(set_b));
      check1("R4 query read record", hit_a, model_hit(set_a, qa));
      check1("R4 query write record", hit_b, model_hit(set_b, qb));
      check1("R6 overlap", ovl_a, model_ovl(set_a, set_b));
      check1("R6 overlap mirror", ovl_b, model_ovl(set_b, set_a));
      @(posedge clk);
      if (ca) set_a.delete(); else if (va) set_a.push_back(ia);
      if (cb) set_b.delete(); else if (vb) set_b.push_back(ib);
   endtask

   initial begin
      #2_000_000;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [AW-1:0] shared;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      checkv("R1 reset vector", sig_a, '0);
      check1("R1 reset hit", hit_a, 1'b0);
      check1("R1 reset overlap", ovl_a, 1'b0);
      @(negedge clk) rst_n = 1'b1;

      // R3 R2 single record, R7 idle holds
      cyc(0, 1, 32'h0000_1040, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 32'h0000_1040, 0, 0, 0, 32'h0000_1040);
      cyc(0, 0, 0, 32'h0000_107F, 0, 0, 0, 0);

      // R5 wipe wins over a same-cycle record
      cyc(1, 1, 32'h0000_2000, 32'h0000_2000, 0, 0, 0, 0);
      cyc(0, 0, 0, 32'h0000_2000, 0, 0, 0, 0);

      // R6 disjoint then shared contents
      for (int n = 0; n < 6; n++)
         cyc(0, 1, 32'h1000_0000 + n * 64, 0, 0, 1, 32'h2345_0000 + n * 4096, 0);
      shared = 32'hABCD_E0C0;
      cyc(0, 1, shared, shared, 0, 1, shared, shared);
      cyc(0, 0, 0, shared, 0, 0, 0, shared);

      // R4 no false negatives over every recorded address
      foreach (set_a[n]) cyc(0, 0, 0, set_a[n], 0, 0, 0, set_b[n % set_b.size()]);

      // Mixed random traffic with occasional wipes (R8 between wipes)
      for (int e = 0; e < 40; e++) begin
         for (int c = 0; c < 30; c++) begin
            logic [AW-1:0] ra, rb, q;
            ra = $urandom; rb = $urandom;
            q = (set_a.size() > 0 && c % 2 == 0) ? set_a[$urandom % set_a.size()] : AW'($urandom);
            cyc(0, ($urandom % 4) != 0, ra, q, 0, ($urandom % 3) == 0, rb, rb);
         end
         foreach (set_a[n]) cyc(0, 0, 0, set_a[n], 0, 0, 0, 0);
         cyc(e % 2 == 0, 1, $urandom, 0, e % 3 == 0, 1, $urandom, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule